// File: doc/BRIEF.md
# Symmetric Boolean Function Evaluator

This block computes any single-output Boolean function of `N_IN` inputs whose value depends only on how many inputs are set. It works in two steps. First it counts the 1s in the input vector. The count is built by a chain of conditional incrementers, one for each input bit after the first. Second, an equality comparator for each possible count value tests the count. The matching comparator's hit is gated by a caller-supplied lookup vector that holds one output bit per count value.

The caller chooses the function by loading the lookup vector. Some examples:
- A threshold function sets every entry at or above a limit.
- Parity sets the odd entries.
- An exactly-k detector sets a single entry.

The count itself is also brought out for observation. A parameter places a register stage after the logic, which adds one cycle of latency. Without it the block is purely combinational.

Top module: `symfn_eval`

## Requirements
- R1: `weight_o` equals the number of 1 bits in `data_i`. It is an unsigned binary value `$clog2(N_IN+1)` bits wide and spans 0 to `N_IN`.
- R2: `result_o` equals `table_i[k]`, where k is the number of 1 bits in `data_i`. Bit position k of `table_i` holds the output for count k.
- R3: Any two input vectors with the same number of 1 bits give the same `result_o` under the same `table_i`. This includes vectors that are permutations of each other.
- R4: While `rst_n` is low, `result_o` and `weight_o` are 0 when `REG_OUT` is 1.
- R5: With `REG_OUT` set to 1, the outputs reflect the inputs present at the previous rising clock edge. With `REG_OUT` set to 0, they follow the inputs in the same cycle.
- R6: The all-zeros input selects `table_i[0]`, and the all-ones input selects `table_i[N_IN]`.
- R7: An all-ones `table_i` gives `result_o` = 1 for every input. An all-zeros `table_i` gives `result_o` = 0 for every input.
- R8: `weight_o[0]` equals the XOR of all bits of `data_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_i | input | N_IN | Input vector |
| table_i | input | N_IN+1 | Output bit for each count value |
| result_o | output | 1 | Function value |
| weight_o | output | $clog2(N_IN+1) | Count of set input bits |

## Verification
The count path and the table path can change in the same cycle. A new input vector can move the count while a new lookup vector rewrites the bit that count selects. The bench provokes this with a run of cycles in which both `data_i` and `table_i` take fresh values together. Each result is judged against the new table indexed by the new count, one cycle later. Exhaustive sweeps of all 256 inputs under threshold, parity and exactly-three tables cover the comparator for every count value.

// File: rtl/symfn_pkg.sv
package symfn_pkg;

    // Bits needed to hold a count from 0 to n inclusive (floor(log2 n)+1).
    function automatic int cnt_bits(input int n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/symfn_incr.sv
// One conditional increment stage: adds bit_i into cnt_i through a
// half-adder carry chain.
module symfn_incr #(
    parameter int W = 4
) (
    input  logic [W-1:0] cnt_i,
    input  logic         bit_i,
    output logic [W-1:0] cnt_o
);
    logic [W-1:0] cy;

    assign cy[0] = bit_i;

    for (genvar b = 0; b < W; b++) begin : g_bit
        assign cnt_o[b] = cnt_i[b] ^ cy[b];
        if (b < W - 1) begin : g_carry
            assign cy[b+1] = cnt_i[b] & cy[b];
        end
    end
endmodule

// File: rtl/symfn_popcnt.sv
// Population count built as a cascade of N-1 incrementers.
module symfn_popcnt #(
    parameter int N = 8,
    parameter int W = 4
) (
    input  logic [N-1:0] data_i,
    output logic [W-1:0] weight_o
);
    logic [W-1:0] stage [N];

    assign stage[0] = {{(W-1){1'b0}}, data_i[0]};

    for (genvar k = 1; k < N; k++) begin : g_stage
        symfn_incr #(.W(W)) u_incr (
            .cnt_i (stage[k-1]),
            .bit_i (data_i[k]),
            .cnt_o (stage[k])
        );
    end

    assign weight_o = stage[N-1];
endmodule

// File: rtl/symfn_match.sv
// One equality comparator per count value (mixed-polarity AND over the
// count bits), OR-reduced after gating with the lookup vector.
module symfn_match #(
    parameter int N = 8,
    parameter int W = 4
) (
    input  logic [W-1:0] weight_i,
    input  logic [N:0]   table_i,
    output logic         result_o
);
    logic [N:0] hit;

    for (genvar w = 0; w <= N; w++) begin : g_cmp
        localparam logic [W-1:0] KEY = W'(w);
        assign hit[w] = &(weight_i ~^ KEY);
    end

    assign result_o = |(hit & table_i);
endmodule

// File: rtl/symfn_eval.sv
module symfn_eval
    import symfn_pkg::*;
#(
    parameter int N_IN    = 8,
    parameter bit REG_OUT = 1'b1,
    localparam int W_CNT  = cnt_bits(N_IN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IN-1:0]  data_i,
    input  logic [N_IN:0]    table_i,
    output logic             result_o,
    output logic [W_CNT-1:0] weight_o
);
    typedef struct packed {
        logic             res;
        logic [W_CNT-1:0] wt;
    } out_s;

    logic [W_CNT-1:0] pc_weight;
    logic             pc_result;
    out_s             out_d;
    out_s             out_q;

    symfn_popcnt #(.N(N_IN), .W(W_CNT)) u_popcnt (
        .data_i   (data_i),
        .weight_o (pc_weight)
    );

    symfn_match #(.N(N_IN), .W(W_CNT)) u_match (
        .weight_i (pc_weight),
        .table_i  (table_i),
        .result_o (pc_result)
    );

    always_comb begin
        out_d     = out_q;
        out_d.res = pc_result;
        out_d.wt  = pc_weight;
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) out_q <= '0;
            else        out_q <= out_d;
        end
    end else begin : g_comb
        // Outputs follow the logic directly; clock and reset are unused.
        logic unused_ok;
        assign unused_ok = clk ^ rst_n;
        assign out_q     = {pc_result, pc_weight};
    end

    assign result_o = out_q.res;
    assign weight_o = out_q.wt;
endmodule

// File: rtl/symfn_eval_chk.sv
module symfn_eval_chk #(
    parameter int N_IN    = 8,
    parameter bit REG_OUT = 1'b1,
    parameter int W_CNT   = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_IN-1:0]  data_i,
    input logic [N_IN:0]    table_i,
    input logic             result_o,
    input logic [W_CNT-1:0] weight_o
);
    logic [W_CNT-1:0] ref_w;
    logic             ref_r;
    logic             ref_par;

    always_comb begin
        ref_w   = W_CNT'($countones(data_i));
        ref_r   = table_i[ref_w];
        ref_par = ^data_i;
    end

    if (REG_OUT) begin : g_reg
        p_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> weight_o == $past(ref_w));
        p_select_r2: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> result_o == $past(ref_r));
        p_reset_r4: assert property (@(posedge clk)
            !rst_n |=> (result_o == 1'b0 && weight_o == '0));
        p_const_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(&table_i)) |-> result_o);
        p_parity_r8: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> weight_o[0] == $past(ref_par));
    end else begin : g_comb
        p_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
            weight_o == ref_w);
        p_select_r2: assert property (@(posedge clk) disable iff (!rst_n)
            result_o == ref_r);
        p_const_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (&table_i) |-> result_o);
        p_parity_r8: assert property (@(posedge clk) disable iff (!rst_n)
            weight_o[0] == ref_par);
    end
endmodule

bind symfn_eval symfn_eval_chk #(
    .N_IN(N_IN), .REG_OUT(REG_OUT), .W_CNT(W_CNT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .data_i(data_i), .table_i(table_i),
    .result_o(result_o), .weight_o(weight_o)
);

// File: tb/symfn_eval_test.sv
module symfn_eval_test;
    localparam int N = 8;
    localparam int W = $clog2(N + 1);

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] data_i = '0;
    logic [N:0]   table_i = '0;
    logic         result_o;
    logic [W-1:0] weight_o;

    int checks = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        int           ready;
        logic         res;
        logic [W-1:0] wt;
        string        req;
    } item_t;

    item_t sb_q[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    symfn_eval uut (
        .clk(clk), .rst_n(rst_n), .data_i(data_i), .table_i(table_i),
        .result_o(result_o), .weight_o(weight_o)
    );

    function automatic int popc(input logic [N-1:0] v);
        int c = 0;
        for (int i = 0; i < N; i++) c += int'(v[i]);
        return c;
    endfunction

    task automatic check(input bit ok, input string req, input string msg);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s", req, msg);
        end
    endtask

    // Driver: apply one stimulus after a rising edge and queue the expectation.
    task automatic drive(input logic [N-1:0] d, input logic [N:0] t, input string req);
        item_t it;
        int    k;
        @(posedge clk);
        #1;
        data_i  = d;
        table_i = t;
        k        = popc(d);
        it.ready = cyc + 1;
        it.wt    = W'(k);
        it.res   = t[k];
        it.req   = req;
        sb_q.push_back(it);
    endtask

    // Monitor: compare results once their capture edge has passed.
    always @(negedge clk) begin
        while (sb_q.size() > 0 && sb_q[0].ready <= cyc) begin
            item_t it;
            it = sb_q.pop_front();
            check(weight_o == it.wt, "R1",
                  $sformatf("weight actual=%0d expected=%0d (%s)", weight_o, it.wt, it.req));
            check(result_o == it.res, it.req,
                  $sformatf("result actual=%0b expected=%0b", result_o, it.res));
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        logic [N:0] thr_t;
        logic [N:0] par_t;
        logic [N:0] ex3_t;
        logic       r_ref;
        thr_t = 9'b1_1111_0000;
        par_t = 9'b0_1010_1010;
        ex3_t = 9'b0_0000_1000;

        data_i  = 8'hFF;
        table_i = '1;
        repeat (3) @(posedge clk);
        #5;
        // R4: held in reset despite active inputs.
        check(result_o == 1'b0 && weight_o == '0, "R4",
              $sformatf("reset actual=%0b/%0d expected=0/0", result_o, weight_o));
        @(negedge clk);
        rst_n = 1'b1;

        // R5: output holds old value until the capture edge.
        drive(8'h00, thr_t, "R6");
        drive(8'h00, thr_t, "R6");
        repeat (2) @(posedge clk);
        @(posedge clk);
        #1;
        data_i = 8'hFF;
        #2;
        check(weight_o == 4'd0, "R5",
              $sformatf("pre-edge actual=%0d expected=0", weight_o));
        @(posedge clk);
        #2;
        check(weight_o == 4'd8, "R5",
              $sformatf("post-edge actual=%0d expected=8", weight_o));

        // R6: boundary counts under one-hot tables.
        drive(8'h00, 9'b0_0000_0001, "R6");
        drive(8'hFF, 9'b1_0000_0000, "R6");
        drive(8'hFF, 9'b0_1111_1111, "R6");

        // Exhaustive sweeps: threshold, parity, exactly three.
        for (int v = 0; v < 256; v++) drive(8'(v), thr_t, "R2");
        for (int v = 0; v < 256; v++) drive(8'(v), par_t, "R8");
        for (int v = 0; v < 256; v++) drive(8'(v), ex3_t, "R2");

        // R7: constant tables.
        for (int v = 0; v < 256; v += 7) drive(8'(v), '1, "R7");
        for (int v = 0; v < 256; v += 5) drive(8'(v), '0, "R7");

        // R3: permutations (rotations) of one pattern under a fixed table.
        for (int r = 0; r < N; r++) begin
            logic [N-1:0] p;
            p = (8'b0010_1101 << r) | (8'b0010_1101 >> (N - r));
            drive(p, 9'b0_0110_1001, "R3");
        end
        // R3: direct comparison across rotations at the ports.
        for (int r = 0; r < N; r++) begin
            logic [N-1:0] p;
            p = (8'b0100_0111 << r) | (8'b0100_0111 >> (N - r));
            @(posedge clk);
            #1;
            data_i  = p;
            table_i = 9'b1_0001_0110;
            @(posedge clk);
            #2;
            if (r == 0) r_ref = result_o;
            check(result_o == r_ref, "R3",
                  $sformatf("rotation %0d actual=%0b expected=%0b", r, result_o, r_ref));
        end

        // R2: data and table change together every cycle.
        for (int i = 0; i < 400; i++) begin
            drive(8'($urandom), 9'($urandom), "R2");
        end

        repeat (4) @(posedge clk);
        @(negedge clk);
        check(sb_q.size() == 0, "R2",
              $sformatf("pending actual=%0d expected=0", sb_q.size()));
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule